// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Mark Wakeup

This block receives asynchronous serial frames on a single data line. A strobe that pulses sixteen times per bit period clocks a small state machine that finds the start edge and checks that the start bit is real. The machine counts sixteen numbered slots per bit and takes each bit value by majority vote near the middle of the bit. It realigns its slot count on falling edges inside the frame, so a transmitter whose bit rate is slightly off is still received correctly.

A finished byte goes into a holding register and raises a ready flag. A read strobe clears that flag. Framing and overrun conditions are also flagged. For multi-drop links there is a sleep mode. While asleep, the receiver drops every frame whose most significant data bit is 0. The first frame with that bit set clears sleep by itself and is delivered normally. Software can put the receiver back to sleep after it sees an address that is not its own.

The state machine has four states:
- IDLE: looking for a start edge.
- START: qualifying the start bit and waiting out its remaining slots.
- DATA: receiving the data bits.
- STOP: sampling the stop bit.

Its transitions are:
- IDLE→START: a high-to-low edge on a sample tick while enabled.
- START→IDLE: the start bit is rejected.
- START→DATA: after start slot 16.
- DATA→STOP: after slot 16 of the last data bit.
- STOP→IDLE: at the stop-bit vote.
- Any state→IDLE: the enable goes low.

Top module: `oversampled_rx`

## Requirements
- R1: While `rx_en` is low the receiver stays in IDLE, keeps `rx_active` low and delivers no byte.
- R2: Slots are counted only on `sample_tick`. The tick that first sees `rxd` low after a high sample is slot 1. `rx_active` is low after slot 6 has been processed and high after slot 7 has been processed.
- R3: A start bit is accepted only if at least two of the samples at slots 3, 5 and 7 are low. Otherwise the receiver returns to IDLE without raising `rx_active` and without delivering anything.
- R4: `rx_active` rises when a start bit is accepted and falls when the frame ends (stop vote) or when the start bit is rejected.
- R5: Each data and stop bit takes the 2-of-3 majority of the samples at slots 8, 9 and 10, so a single wrong sample in that window does not change the bit.
- R6: Inside DATA and STOP, a falling edge seen when the previous slot was 10 or later starts slot 1 of the next bit. A falling edge seen when the previous slot was 6 or earlier restarts the current bit at slot 1. Edges at slots 7 to 9 are ignored.
- R7: A frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The assembled byte appears on `rx_data` and `data_ready` goes high.
- R8: `framing_err` is loaded with 1 when the stop-bit vote is low and with 0 when it is high, together with each byte written to `rx_data`.
- R9: A `rd_strobe` pulse clears `data_ready` and `overrun`.
- R10: If a byte completes while `data_ready` is high and no read occurs in that cycle, `overrun` is set and `rx_data` keeps the older byte.
- R11: A `sleep_req` pulse sets `sleeping`. While `sleeping` is high, a frame with data bit 7 equal to 1 clears `sleeping` and is delivered like any other byte.
- R12: While `sleeping` is high, a frame with data bit 7 equal to 0 leaves `rx_data`, `data_ready`, `framing_err` and `overrun` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| sleep_req | input | 1 | One-cycle pulse that puts the receiver to sleep |
| sample_tick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rxd | input | 1 | Serial data line, already synchronous to `clk` |
| rd_strobe | input | 1 | One-cycle pulse that acknowledges the held byte |
| rx_data | output | 8 | Last delivered byte |
| rx_active | output | 1 | A qualified frame is in progress |
| data_ready | output | 1 | `rx_data` holds an unread byte |
| framing_err | output | 1 | Stop bit of the held byte was sampled low |
| overrun | output | 1 | A completed byte was dropped because the previous one was unread |
| sleeping | output | 1 | Receiver is waiting for a frame with bit 7 set |

## Verification
A slot counter that drifts or a missed realignment shows up at the ports as a wrong bit in `rx_data` within one frame. The stretched-bit and shortened-bit frames are built so that this drift flips a bit before the stop bit. A wrong state transition shows within a few ticks as a late or missing `rx_active`. A wrong sleep or overrun decision shows one clock after the stop-bit vote, either as `data_ready` changing when it should hold or as `rx_data` being replaced.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP
    } rx_state_t;
endpackage

// File: rtl/rx_majority.sv
// Captures the line at two slots and votes with the line level at a third.
module rx_majority #(
    parameter int SW = 5,
    parameter int SA = 3,
    parameter int SB = 5,
    parameter int SC = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [SW-1:0] slot,
    input  logic          rxd,
    output logic          fire,
    output logic          vote
);
    logic sa_q, sb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa_q <= 1'b1;
            sb_q <= 1'b1;
        end else if (tick) begin
            if (slot == SW'(SA)) sa_q <= rxd;
            if (slot == SW'(SB)) sb_q <= rxd;
        end
    end

    assign fire = tick && (slot == SW'(SC));
    assign vote = (sa_q & sb_q) | (sa_q & rxd) | (sb_q & rxd);
endmodule

// File: rtl/rx_deliver.sv
// Holding register, ready/overrun/framing flags and the sleep bit.
module rx_deliver #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] byte_in,
    input  logic          stop_ok,
    input  logic          sleep_req,
    input  logic          rd_strobe,
    output logic [DW-1:0] data_q,
    output logic          ready_q,
    output logic          ferr_q,
    output logic          ovr_q,
    output logic          sleep_q
);
    logic accept;
    assign accept = done && (!sleep_q || byte_in[DW-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            ferr_q  <= 1'b0;
            ovr_q   <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            if (sleep_req)
                sleep_q <= 1'b1;
            else if (done && byte_in[DW-1])
                sleep_q <= 1'b0;

            if (rd_strobe) begin
                ready_q <= 1'b0;
                ovr_q   <= 1'b0;
            end

            if (accept) begin
                if (ready_q && !rd_strobe) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q  <= byte_in;
                    ready_q <= 1'b1;
                    ferr_q  <= !stop_ok;
                end
            end
        end
    end
endmodule

// File: rtl/oversampled_rx.sv
module oversampled_rx #(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8,
    parameter int START_S1   = 3,
    parameter int START_S2   = 5,
    parameter int START_S3   = 7,
    parameter int BIT_S1     = 8,
    parameter int BIT_S2     = 9,
    parameter int BIT_S3     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 sleep_req,
    input  logic                 sample_tick,
    input  logic                 rxd,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_active,
    output logic                 data_ready,
    output logic                 framing_err,
    output logic                 overrun,
    output logic                 sleeping
);
    import rx_pkg::*;

    localparam int SW        = $clog2(OVERSAMPLE + 1);
    localparam int BW        = $clog2(DATA_BITS);
    localparam int LATE_FROM = BIT_S3;
    localparam int EARLY_TO  = BIT_S1 - 2;

    rx_state_t             state_q, state_d;
    logic [SW-1:0]         slot_q, slot_d, slot_now;
    logic [BW-1:0]         bit_q, bit_d;
    logic [DATA_BITS-1:0]  shreg_q, shreg_d;
    logic                  active_q, active_d;
    logic                  rxd_q;
    logic                  fall, adv;
    logic                  st_fire, st_vote, bt_fire, bt_vote;
    logic                  frame_done;

    assign fall = sample_tick && rxd_q && !rxd;

    // Slot number of the current tick, with in-frame realignment.
    always_comb begin
        adv      = (slot_q == SW'(OVERSAMPLE));
        slot_now = adv ? SW'(1) : slot_q + SW'(1);
        if (fall && (state_q == S_DATA || state_q == S_STOP)) begin
            if (slot_q >= SW'(LATE_FROM)) begin
                slot_now = SW'(1);
                adv      = 1'b1;
            end else if (slot_q <= SW'(EARLY_TO)) begin
                slot_now = SW'(1);
                adv      = 1'b0;
            end
        end
    end

    rx_majority #(.SW(SW), .SA(START_S1), .SB(START_S2), .SC(START_S3)) u_start_vote (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .slot(slot_now),
        .rxd(rxd), .fire(st_fire), .vote(st_vote)
    );

    rx_majority #(.SW(SW), .SA(BIT_S1), .SB(BIT_S2), .SC(BIT_S3)) u_bit_vote (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .slot(slot_now),
        .rxd(rxd), .fire(bt_fire), .vote(bt_vote)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            slot_q   <= SW'(OVERSAMPLE);
            bit_q    <= '0;
            shreg_q  <= '0;
            active_q <= 1'b0;
            rxd_q    <= 1'b1;
        end else begin
            state_q  <= state_d;
            slot_q   <= slot_d;
            bit_q    <= bit_d;
            shreg_q  <= shreg_d;
            active_q <= active_d;
            if (sample_tick) rxd_q <= rxd;
        end
    end

    // Next state and frame completion.
    always_comb begin
        state_d    = state_q;
        slot_d     = slot_q;
        bit_d      = bit_q;
        shreg_d    = shreg_q;
        active_d   = active_q;
        frame_done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                slot_d = SW'(OVERSAMPLE);
                if (rx_en && fall) begin
                    state_d = S_START;
                    slot_d  = SW'(1);
                end
            end
            S_START: begin
                if (sample_tick) begin
                    slot_d = slot_now;
                    if (st_fire) begin
                        if (!st_vote) begin
                            active_d = 1'b1;
                        end else begin
                            state_d = S_IDLE;
                            slot_d  = SW'(OVERSAMPLE);
                        end
                    end else if (adv) begin
                        state_d = S_DATA;
                        bit_d   = '0;
                    end
                end
            end
            S_DATA: begin
                if (sample_tick) begin
                    slot_d = slot_now;
                    if (bt_fire)
                        shreg_d = {bt_vote, shreg_q[DATA_BITS-1:1]};
                    if (adv) begin
                        if (bit_q == BW'(DATA_BITS - 1))
                            state_d = S_STOP;
                        else
                            bit_d = bit_q + BW'(1);
                    end
                end
            end
            S_STOP: begin
                if (sample_tick) begin
                    slot_d = slot_now;
                    if (bt_fire) begin
                        frame_done = 1'b1;
                        state_d    = S_IDLE;
                        active_d   = 1'b0;
                        slot_d     = SW'(OVERSAMPLE);
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (!rx_en) begin
            state_d    = S_IDLE;
            active_d   = 1'b0;
            slot_d     = SW'(OVERSAMPLE);
            frame_done = 1'b0;
        end
    end

    rx_deliver #(.DW(DATA_BITS)) u_deliver (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .byte_in(shreg_q),
        .stop_ok(bt_vote), .sleep_req(sleep_req), .rd_strobe(rd_strobe),
        .data_q(rx_data), .ready_q(data_ready), .ferr_q(framing_err),
        .ovr_q(overrun), .sleep_q(sleeping)
    );

    assign rx_active = active_q;
endmodule

// File: rtl/oversampled_rx_chk.sv
module oversampled_rx_chk #(
    parameter int SW = 5,
    parameter int OVERSAMPLE = 16,
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_strobe,
    input logic              rx_active,
    input logic              data_ready,
    input logic              overrun,
    input logic              sleeping,
    input logic [DW-1:0]     rx_data,
    input logic [SW-1:0]     slot,
    input rx_pkg::rx_state_t state
);
    p_enable_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_active);

    p_slot_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state != rx_pkg::S_IDLE |-> (slot >= SW'(1) && slot <= SW'(OVERSAMPLE)));

    p_active_before_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_active));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !rx_active |=> !data_ready && !overrun);

    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready && !rd_strobe |=> $stable(rx_data));

    p_wake_on_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping) |-> $past(rx_active));

    p_asleep_needs_msb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) && $past(sleeping) |-> rx_data[DW-1]);
endmodule

bind oversampled_rx oversampled_rx_chk #(.SW(SW), .OVERSAMPLE(OVERSAMPLE), .DW(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .rx_active(rx_active), .data_ready(data_ready), .overrun(overrun),
    .sleeping(sleeping), .rx_data(rx_data), .slot(slot_q), .state(state_q)
);

// File: tb/oversampled_rx_test.sv
module oversampled_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {set_sleep, byte[7:0], stop, exp_taken, exp_ferr, exp_sleep}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'hA3, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h12, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b1},
        {1'b0, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, sleep_req = 1'b0;
    logic sample_tick = 1'b0, rxd = 1'b1, rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic rx_active, data_ready, framing_err, overrun, sleeping;
    int total = 0, bad = 0, cycles = 0;
    logic [7:0] held;

    oversampled_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sleep_req(sleep_req),
        .sample_tick(sample_tick), .rxd(rxd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_active(rx_active), .data_ready(data_ready),
        .framing_err(framing_err), .overrun(overrun), .sleeping(sleeping)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick_once(input logic v);
        @(negedge clk); rxd = v; sample_tick = 1'b1;
        @(negedge clk); sample_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input int n);
        for (int k = 0; k < n; k++) tick_once(v);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stopv);
        send_bit(1'b0, 16);
        for (int i = 0; i < 8; i++) send_bit(b[i], 16);
        send_bit(stopv, 16);
        send_bit(1'b1, 2);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    // Frame whose high data bits last hi_len ticks, low bits 16.
    task automatic send_skewed(input logic [7:0] b, input int hi_len);
        send_bit(1'b0, 16);
        for (int i = 0; i < 8; i++) send_bit(b[i], b[i] ? hi_len : 16);
        send_bit(1'b1, 16);
        send_bit(1'b1, 2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R7 reset ready", data_ready, 0);
        chk("R4 reset active", rx_active, 0);
        chk("R11 reset sleeping", sleeping, 0);
        chk("R10 reset overrun", overrun, 0);

        // R1: disabled receiver ignores a frame
        send_frame(8'h5A, 1'b1);
        chk("R1 disabled no byte", data_ready, 0);
        chk("R1 disabled inactive", rx_active, 0);
        rx_en = 1'b1;
        send_bit(1'b1, 2);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            pulse(rd_strobe);
            if (VEC[v][12]) pulse(sleep_req);
            held = rx_data;
            send_frame(VEC[v][11:4], VEC[v][3]);
            chk("R7/R12 ready", data_ready, VEC[v][2]);
            chk("R7/R12 data", rx_data, VEC[v][2] ? VEC[v][11:4] : held);
            if (VEC[v][2]) chk("R8 framing", framing_err, VEC[v][1]);
            chk("R11 sleeping", sleeping, VEC[v][0]);
        end

        // R2/R4: active timing within the start bit
        pulse(rd_strobe);
        send_bit(1'b0, 6);
        chk("R2 active not yet", rx_active, 0);
        send_bit(1'b0, 1);
        chk("R2 R4 active at slot 7", rx_active, 1);
        send_bit(1'b0, 9);
        for (int i = 0; i < 8; i++) send_bit(1'b1, 16);
        send_bit(1'b1, 16);
        send_bit(1'b1, 2);
        chk("R4 active cleared", rx_active, 0);
        chk("R7 byte ff", rx_data, 8'hFF);

        // R3: short glitch rejected
        pulse(rd_strobe);
        send_bit(1'b0, 2);
        send_bit(1'b1, 8);
        chk("R3 glitch not active", rx_active, 0);
        send_bit(1'b1, 180);
        chk("R3 glitch no byte", data_ready, 0);

        // R5: one low sample at slot 9 of bit 3
        send_bit(1'b0, 16);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 16);
        send_bit(1'b1, 8); send_bit(1'b0, 1); send_bit(1'b1, 7);
        for (int i = 4; i < 8; i++) send_bit(1'b1, 16);
        send_bit(1'b1, 18);
        chk("R5 majority", rx_data, 8'hFF);

        // R6: late edges (stretched high bits) and early edges
        pulse(rd_strobe);
        send_skewed(8'h55, 19);
        chk("R6 late realign", rx_data, 8'h55);
        pulse(rd_strobe);
        send_skewed(8'h55, 13);
        chk("R6 early realign", rx_data, 8'h55);
        chk("R6 ready", data_ready, 1);

        // R10/R9: overrun keeps older byte, read clears
        pulse(rd_strobe);
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        chk("R10 overrun set", overrun, 1);
        chk("R10 older kept", rx_data, 8'h11);
        pulse(rd_strobe);
        @(negedge clk);
        chk("R9 ready cleared", data_ready, 0);
        chk("R9 overrun cleared", overrun, 0);

        // R11/R12: sleep, skip MSB0, wake on MSB1 while byte unread path
        pulse(sleep_req);
        chk("R11 sleep set", sleeping, 1);
        send_frame(8'h44, 1'b1);
        chk("R12 asleep no ready", data_ready, 0);
        chk("R12 asleep data kept", rx_data, 8'h11);
        send_frame(8'hC4, 1'b1);
        chk("R11 woke", sleeping, 0);
        chk("R11 address byte", rx_data, 8'hC4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule